// File: doc/BRIEF.md
# Synchronous Burst Flash Read Port

This block is the memory side of a 32-bit flash read interface. A host presents an address, pulses a latch-enable strobe while the chip is enabled, and then receives data. After reset the port answers reads asynchronously. In that mode a word is driven onto the data outputs while the chip and output enables are low and write-enable is high. Once the host has written a synchronous setting into the 16-bit configuration word, every latch starts a burst. The first beat arrives after a configured number of clocks. The following beats step through the array in sequential or interleaved order, with or without wrap, over a fixed block of four or eight words or without limit.

A burst-advance input lets the host stall the burst. While it is high, the current beat stays on the bus. A ready output marks the clock edge at which each beat is valid, or the cycle before it. Writes are single-cycle. The top address bit chooses between the configuration word and the small internal array. The data bus is modelled as a data output with a separate drive-enable. When the drive-enable is low the data output reads zero.

Top module: `sbf_read_port`

## Requirements
- R1: After reset the port is in asynchronous mode, the configuration word holds 16'hA08F, and neither data drive-enable nor ready is asserted.
- R2: In asynchronous mode, with `ce_n`, `oe_n` low and `we_n` high, `dq_o` shows the addressed array word in the same cycle. When `addr[AW]` is 1 it shows the configuration word in bits 15:0, with zeros above.
- R3: A rising edge with `ce_n`, `lat_n` and `we_n` all low is a write. It stores `wdata` into array word `addr[AW-1:0]` when `addr[AW]` is 0, or offers `wdata[15:0]` to the configuration word when `addr[AW]` is 1. A write also ends any burst.
- R4: The configuration fields are as follows. Bit 15 = 1 selects asynchronous mode. Bits 13:11 hold the latency code. Bit 9 = 1 selects two-cycle beats. Bit 8 = 1 selects early ready. Bit 7 = 1 selects sequential order and 0 interleaved order. Bit 3 = 1 selects no wrap. Bits 2:0 hold the length: 001 = 4 words, 010 = 8 words, 111 = continuous. A written value is dropped, and the old word kept, in any of these cases: the latency code lies outside 010..110; the length code is not one of the three listed; latency code 010 is combined with two-cycle beats; bit 6, 14, 10, 5 or 4 is set; continuous length is used with wrap; or interleaved order is used with no wrap or with continuous length.
- R5: In synchronous mode, a latch edge with `we_n` high starts a burst. The first beat is driven after X-1 further rising edges, where X = latency code + 2 (4 to 8). `dq_oe_o` is low until then.
- R6: With bit 9 = 0 each beat lasts one cycle. With bit 9 = 1 each beat lasts at least two cycles.
- R7: The beat index advances only at the last cycle of a beat where `adv_n` is low. While `adv_n` is high the same word stays on the bus.
- R8: With sequential order and wrap, the word for beat i is the base address with its low bits replaced by (base + i) mod L, where L is 4 or 8.
- R9: With interleaved order, the word for beat i is the base address with its low bits replaced by (base XOR i) mod L.
- R10: With no wrap or continuous length, the word for beat i is (base + i) mod 64, so the sequence crosses block boundaries and wraps at the end of the array.
- R11: With bit 8 = 0, `rdy_o` is high in the final cycle of each beat. With bit 8 = 1 it is high one cycle earlier. That includes the last latency cycle when beats are one cycle long. `rdy_o` is always low in asynchronous mode.
- R12: `ce_n` high removes drive and ready in the same cycle and ends the burst at the next edge. Lowering `ce_n` again without a latch edge does not resume the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| lat_n | input | 1 | Address latch enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW+1 (7) | Word address; top bit selects the configuration word |
| wdata | input | DW (32) | Write data |
| dq_o | output | DW (32) | Read data, zero when not driven |
| dq_oe_o | output | 1 | Data drive-enable, stands in for the tri-state control |
| rdy_o | output | 1 | Beat-valid indication |

## Verification
The bound checker tests several rules on every clock. Chip-enable high removes drive at once and clears the burst at the next edge. A high burst-advance freezes the beat address. A rejected configuration write leaves the word unchanged. Asynchronous mode never shows a burst or a ready. The first beat appears exactly X-1 edges after its latch. In normal ready mode, ready is seen only inside a beat. The bench's reference model compares data, drive-enable and ready on every cycle. Only its scenarios can show the actual word order for sequential, interleaved, no-wrap and continuous bursts, the two-cycle beat shape, the early-ready timing, and the readback of rejected configuration values.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int unsigned CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hA08F;

  localparam logic [2:0] LEN_4    = 3'b001;
  localparam logic [2:0] LEN_8    = 3'b010;
  localparam logic [2:0] LEN_CONT = 3'b111;
  localparam logic [2:0] XLAT_MIN = 3'b010;
  localparam logic [2:0] XLAT_MAX = 3'b110;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BEAT} seq_state_e;

  typedef struct packed {
    logic       async_mode;
    logic [2:0] xlat;
    logic       two_cycle;
    logic       rdy_early;
    logic       sequential;
    logic       wrap_off;
    logic [2:0] len;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] v);
    cfg_t c;
    c.async_mode = v[15];
    c.xlat       = v[13:11];
    c.two_cycle  = v[9];
    c.rdy_early  = v[8];
    c.sequential = v[7];
    c.wrap_off   = v[3];
    c.len        = v[2:0];
    return c;
  endfunction

  function automatic logic cfg_legal(input logic [CFG_W-1:0] v);
    cfg_t c;
    logic ok;
    c  = cfg_unpack(v);
    ok = (c.xlat >= XLAT_MIN) && (c.xlat <= XLAT_MAX);
    if (!(c.len == LEN_4 || c.len == LEN_8 || c.len == LEN_CONT)) ok = 1'b0;
    if (c.xlat == XLAT_MIN && c.two_cycle) ok = 1'b0;
    if (v[14] || v[10] || v[6] || v[5] || v[4]) ok = 1'b0;
    if (c.len == LEN_CONT && !c.wrap_off) ok = 1'b0;
    if (!c.sequential && (c.wrap_off || c.len == LEN_CONT)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/sbf_cfg_reg.sv
module sbf_cfg_reg
  import sbf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_val,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wr_reject
);
  logic legal;

  always_comb begin
    legal     = cfg_legal(wr_val);
    wr_reject = wr_en && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cfg_q <= CFG_RESET;
    else if (wr_en && legal) cfg_q <= wr_val;
  end
endmodule

// File: rtl/sbf_array.sv
module sbf_array #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sbf_burst_seq.sv
module sbf_burst_seq
  import sbf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          lat_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  input  cfg_t          cfg,
  output logic          in_wait,
  output logic          in_beat,
  output logic          lat_fire,
  output logic          rdy_raw,
  output logic [AW-1:0] cur_addr
);
  seq_state_e    st;
  logic [2:0]    wait_cnt;
  logic          phase;
  logic [AW-1:0] base_q;
  logic [AW-1:0] idx_q;
  logic          wait_done;
  logic          rdy_norm;
  logic          rdy_pre;

  // Word address of beat idx for the selected order and wrap mode.
  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                             input logic [AW-1:0] idx,
                                             input logic [2:0]    len,
                                             input logic          wrap_off,
                                             input logic          sequential);
    logic [AW-1:0] blk;
    logic [AW-1:0] lin;
    blk = (len == LEN_8) ? AW'(7) : AW'(3);
    lin = base + idx;
    if (wrap_off || len == LEN_CONT) return lin;
    if (sequential) return (base & ~blk) | (lin & blk);
    return (base & ~blk) | ((base ^ idx) & blk);
  endfunction

  // Latency counter load: X-2 edges of waiting after the latch edge.
  function automatic logic [2:0] wait_load(input logic [2:0] code);
    return code;
  endfunction

  always_comb begin
    lat_fire  = !ce_n && !lat_n && we_n && !cfg.async_mode;
    in_wait   = (st == ST_WAIT);
    in_beat   = (st == ST_BEAT);
    wait_done = in_wait && (wait_cnt == 3'd0);
    rdy_norm  = in_beat && (!cfg.two_cycle || phase);
    rdy_pre   = (wait_done && !cfg.two_cycle) || (in_beat && (!cfg.two_cycle || !phase));
    rdy_raw   = cfg.rdy_early ? rdy_pre : rdy_norm;
    cur_addr  = beat_addr(base_q, idx_q, cfg.len, cfg.wrap_off, cfg.sequential);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      phase    <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
    end else if (ce_n) begin
      st <= ST_IDLE;
    end else if (!lat_n) begin
      if (lat_fire) begin
        st       <= ST_WAIT;
        wait_cnt <= wait_load(cfg.xlat);
        phase    <= 1'b0;
        base_q   <= addr_in;
        idx_q    <= '0;
      end else begin
        st <= ST_IDLE;
      end
    end else begin
      unique case (st)
        ST_WAIT: begin
          if (wait_done) st <= ST_BEAT;
          else           wait_cnt <= wait_cnt - 3'd1;
        end
        ST_BEAT: begin
          if (cfg.two_cycle && !phase) begin
            phase <= 1'b1;
          end else if (!adv_n) begin
            phase <= 1'b0;
            idx_q <= idx_q + AW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbf_read_port.sv
module sbf_read_port
  import sbf_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          lat_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          rdy_o
);
  localparam int unsigned PAD_W = DW - CFG_W;

  logic             wr_cycle;
  logic             cfg_sel;
  logic             cfg_wr;
  logic             arr_wr;
  logic             cfg_rej;
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic             async_mode_w;
  logic [2:0]       xlat_w;
  logic             early_w;
  logic             in_wait;
  logic             in_beat;
  logic             lat_fire;
  logic             rdy_raw;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic             async_rd;
  logic             sync_rd;

  always_comb begin
    wr_cycle     = !ce_n && !lat_n && !we_n;
    cfg_sel      = addr[AW];
    cfg_wr       = wr_cycle && cfg_sel;
    arr_wr       = wr_cycle && !cfg_sel;
    cfg          = cfg_unpack(cfg_q);
    async_mode_w = cfg.async_mode;
    xlat_w       = cfg.xlat;
    early_w      = cfg.rdy_early;
  end

  sbf_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_val    (wdata[CFG_W-1:0]),
    .cfg_q     (cfg_q),
    .wr_reject (cfg_rej)
  );

  sbf_burst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .lat_n    (lat_n),
    .we_n     (we_n),
    .adv_n    (adv_n),
    .addr_in  (addr[AW-1:0]),
    .cfg      (cfg),
    .in_wait  (in_wait),
    .in_beat  (in_beat),
    .lat_fire (lat_fire),
    .rdy_raw  (rdy_raw),
    .cur_addr (cur_addr)
  );

  sbf_array #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (arr_wr),
    .wr_addr (addr[AW-1:0]),
    .wr_data (wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_comb begin
    rd_addr  = async_mode_w ? addr[AW-1:0] : cur_addr;
    async_rd = async_mode_w && !ce_n && !oe_n && we_n;
    sync_rd  = !async_mode_w && in_beat && !ce_n && !oe_n;
    dq_oe_o  = async_rd || sync_rd;
    if (!dq_oe_o)                     dq_o = '0;
    else if (async_mode_w && cfg_sel) dq_o = {{PAD_W{1'b0}}, cfg_q};
    else                              dq_o = rd_data;
    rdy_o    = !async_mode_w && !ce_n && rdy_raw;
  end
endmodule

// File: rtl/sbf_read_port_chk.sv
module sbf_read_port_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          lat_n,
  input logic          adv_n,
  input logic          dq_oe_o,
  input logic          rdy_o,
  input logic          in_wait,
  input logic          in_beat,
  input logic          lat_fire,
  input logic [AW-1:0] cur_addr,
  input logic [15:0]   cfg_q,
  input logic          cfg_wr,
  input logic          cfg_rej,
  input logic          async_mode_w,
  input logic [2:0]    xlat_w,
  input logic          early_w
);
  logic [3:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (lat_fire)    age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  assert_ce_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe_o && !rdy_o));

  assert_ce_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!in_wait && !in_beat));

  assert_adv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_beat && adv_n && !ce_n && lat_n) |=> $stable(cur_addr));

  assert_cfg_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rej) |=> $stable(cfg_q));

  assert_async_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode_w |-> (!in_beat && !in_wait && !rdy_o));

  assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_beat) |-> (age == ({1'b0, xlat_w} + 4'd1)));

  assert_rdy_in_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_w && rdy_o) |-> in_beat);
endmodule

bind sbf_read_port sbf_read_port_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_n         (ce_n),
  .lat_n        (lat_n),
  .adv_n        (adv_n),
  .dq_oe_o      (dq_oe_o),
  .rdy_o        (rdy_o),
  .in_wait      (in_wait),
  .in_beat      (in_beat),
  .lat_fire     (lat_fire),
  .cur_addr     (cur_addr),
  .cfg_q        (cfg_q),
  .cfg_wr       (cfg_wr),
  .cfg_rej      (cfg_rej),
  .async_mode_w (async_mode_w),
  .xlat_w       (xlat_w),
  .early_w      (early_w)
);

// File: tb/test_sbf_read_port.sv
`timescale 1ns/1ps
module test_sbf_read_port;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, lat_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW:0]   addr = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] dq_o;
  wire           dq_oe_o;
  wire           rdy_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string req = "R1";

  always #2 clk = ~clk;

  sbf_read_port #(.DW(DW), .AW(AW)) i_sbf_read_port (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lat_n(lat_n), .adv_n(adv_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .rdy_o(rdy_o));

  // Behavioural reference model
  logic [31:0] m_mem [DEPTH];
  int m_cfg = 'hA08F;
  int m_busy = 0, m_wait = 0, m_elapsed = 0, m_idx = 0, m_phase = 0, m_base = 0;

  function automatic int fld(int v, int lo, int w);
    return (v >> lo) & ((1 << w) - 1);
  endfunction

  function automatic int mkcfg(int asy, int code, int two, int early, int seq, int nowrap, int len);
    return (asy << 15) | (code << 11) | (two << 9) | (early << 8) | (seq << 7) | (nowrap << 3) | len;
  endfunction

  function automatic bit legal(int v);
    int code = fld(v, 11, 3);
    int len  = fld(v, 0, 3);
    if ((v & 'h4470) != 0) return 0;
    if (code < 2 || code > 6) return 0;
    if (len != 1 && len != 2 && len != 7) return 0;
    if (code == 2 && fld(v, 9, 1) == 1) return 0;
    if (len == 7 && fld(v, 3, 1) == 0) return 0;
    if (fld(v, 7, 1) == 0 && (fld(v, 3, 1) == 1 || len == 7)) return 0;
    return 1;
  endfunction

  function automatic int lat_x();
    return fld(m_cfg, 11, 3) + 2;
  endfunction

  function automatic int maddr();
    int len = fld(m_cfg, 0, 3);
    int L   = (len == 2) ? 8 : 4;
    int off = m_base % L;
    if (len == 7 || fld(m_cfg, 3, 1) == 1) return (m_base + m_idx) % DEPTH;
    if (fld(m_cfg, 7, 1) == 1) return m_base - off + (off + m_idx) % L;
    return m_base - off + (off ^ (m_idx % L));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 'hA08F; m_busy = 0;
    end else if (ce_n) begin
      m_busy = 0;
    end else if (!lat_n) begin
      if (!we_n) begin
        m_busy = 0;
        if (addr[AW]) begin
          if (legal(int'(wdata[15:0]))) m_cfg = int'(wdata[15:0]);
        end else begin
          m_mem[addr[AW-1:0]] = wdata;
        end
      end else if (fld(m_cfg, 15, 1) == 0) begin
        m_busy = 1; m_wait = 1; m_elapsed = 0; m_idx = 0; m_phase = 0; m_base = int'(addr[AW-1:0]);
      end else begin
        m_busy = 0;
      end
    end else if (m_busy == 1) begin
      if (m_wait == 1) begin
        m_elapsed++;
        if (m_elapsed == lat_x() - 1) m_wait = 0;
      end else if (fld(m_cfg, 9, 1) == 1 && m_phase == 0) begin
        m_phase = 1;
      end else if (!adv_n) begin
        m_idx++; m_phase = 0;
      end
    end
  end

  task automatic step();
    logic [31:0] e_dq;
    logic e_oe, e_rdy;
    bit asy, two;
    @(negedge clk);
    asy = fld(m_cfg, 15, 1) == 1;
    two = fld(m_cfg, 9, 1) == 1;
    e_oe = !ce_n && !oe_n && (asy ? we_n : (m_busy == 1 && m_wait == 0));
    if (!e_oe)         e_dq = '0;
    else if (!asy)     e_dq = m_mem[maddr()];
    else if (addr[AW]) e_dq = 32'(m_cfg);
    else               e_dq = m_mem[addr[AW-1:0]];
    if (asy || ce_n || m_busy == 0) e_rdy = 1'b0;
    else if (fld(m_cfg, 8, 1) == 1)
      e_rdy = (m_wait == 1 && !two && m_elapsed == lat_x() - 2) || (m_wait == 0 && (!two || m_phase == 0));
    else
      e_rdy = (m_wait == 0 && (!two || m_phase == 1));
    checks++;
    if (dq_o !== e_dq || dq_oe_o !== e_oe || rdy_o !== e_rdy) begin
      fails++;
      $display("FAIL %s: dq=%h oe=%b rdy=%b expected dq=%h oe=%b rdy=%b",
               req, dq_o, dq_oe_o, rdy_o, e_dq, e_oe, e_rdy);
    end
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; lat_n = 1; we_n = 1; oe_n = 1; adv_n = 1;
    step();
  endtask

  task automatic wr(int a, logic [31:0] d);
    ce_n = 0; lat_n = 0; we_n = 0; oe_n = 1; addr = (AW+1)'(a); wdata = d;
    step();
    idle();
  endtask

  task automatic aread(int a, output logic [31:0] v);
    ce_n = 0; lat_n = 1; we_n = 1; oe_n = 0; addr = (AW+1)'(a);
    step();
    v = dq_o;
    idle();
  endtask

  task automatic burst(int a, int cycles, logic [31:0] advpat, output int first_j);
    first_j = -1;
    ce_n = 0; oe_n = 0; we_n = 1; lat_n = 0; adv_n = 1; addr = (AW+1)'(a);
    step();
    lat_n = 1;
    for (int j = 1; j <= cycles; j++) begin
      adv_n = advpat[j % 32];
      step();
      if (dq_oe_o && first_j < 0) first_j = j;
    end
    idle();
  endtask

  initial begin
    logic [31:0] v;
    int fj;
    req = "R1";
    repeat (3) step();
    chk("R1", {30'd0, dq_oe_o, rdy_o}, 32'd0);
    rst_n = 1;
    step();
    aread(DEPTH, v);
    chk("R1", v, 32'h0000A08F);

    req = "R3";
    for (int i = 0; i < DEPTH; i++) wr(i, 32'h9E3779B1 * i + 32'h1234);
    req = "R2";
    aread(0, v);  chk("R2", v, 32'h1234);
    aread(37, v); chk("R2", v, 32'h9E3779B1 * 37 + 32'h1234);
    req = "R3";
    wr(37, 32'hCAFEF00D);
    aread(37, v); chk("R3", v, 32'hCAFEF00D);

    req = "R4";
    wr(DEPTH, mkcfg(0, 0, 0, 0, 1, 0, 1));
    wr(DEPTH, mkcfg(0, 4, 0, 0, 1, 0, 3));
    wr(DEPTH, mkcfg(0, 2, 1, 0, 1, 0, 1));
    wr(DEPTH, mkcfg(0, 4, 0, 0, 0, 1, 2));
    wr(DEPTH, mkcfg(0, 4, 0, 0, 1, 0, 7));
    wr(DEPTH, mkcfg(0, 4, 0, 0, 1, 0, 1) | 'h40);
    aread(DEPTH, v); chk("R4", v, 32'h0000A08F);

    req = "R5";
    wr(DEPTH, mkcfg(0, 4, 0, 0, 1, 0, 1));
    aread(3, v); chk("R5", {31'd0, dq_oe_o}, 32'd0);
    req = "R8";
    burst(5, 12, 32'h0, fj); chk("R5", 32'(fj), 32'd5);
    burst(2, 9, 32'h0, fj);
    req = "R7";
    burst(9, 14, 32'h0000_0A50, fj);

    req = "R6";
    wr(DEPTH, mkcfg(0, 3, 1, 0, 1, 0, 2));
    burst(13, 16, 32'h0000_0300, fj); chk("R5", 32'(fj), 32'd4);

    req = "R9";
    wr(DEPTH, mkcfg(0, 2, 0, 0, 0, 0, 2));
    burst(13, 12, 32'h0, fj); chk("R5", 32'(fj), 32'd3);
    wr(DEPTH, mkcfg(0, 5, 1, 0, 0, 0, 1));
    burst(6, 14, 32'h0, fj);

    req = "R10";
    wr(DEPTH, mkcfg(0, 4, 0, 0, 1, 1, 2));
    burst(60, 14, 32'h0, fj);
    wr(DEPTH, mkcfg(0, 6, 0, 0, 1, 1, 7));
    burst(62, 16, 32'h0000_0800, fj); chk("R5", 32'(fj), 32'd7);

    req = "R11";
    wr(DEPTH, mkcfg(0, 5, 0, 1, 1, 0, 1));
    burst(20, 12, 32'h0000_0200, fj);
    wr(DEPTH, mkcfg(0, 3, 1, 1, 1, 0, 2));
    burst(41, 14, 32'h0, fj);

    req = "R12";
    wr(DEPTH, mkcfg(0, 2, 0, 0, 1, 0, 1));
    ce_n = 0; oe_n = 0; we_n = 1; lat_n = 0; adv_n = 0; addr = 7'd8;
    step();
    lat_n = 1;
    repeat (5) step();
    ce_n = 1;
    #1 chk("R12", {31'd0, dq_oe_o}, 32'd0);
    step();
    ce_n = 0;
    step();
    chk("R12", {31'd0, dq_oe_o}, 32'd0);
    repeat (3) step();
    idle();

    req = "R2";
    wr(DEPTH, 32'h0000A08F);
    aread(37, v); chk("R2", v, 32'hCAFEF00D);
    ce_n = 0; lat_n = 0; we_n = 1; oe_n = 0; addr = 7'd4;
    step();
    lat_n = 1;
    repeat (3) step();
    chk("R11", {31'd0, rdy_o}, 32'd0);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule